// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This block computes the integer multiply, divide and remainder results of a 32-bit processor's multiply-divide instruction group. The surrounding pipeline has already decoded the instruction. It hands over only the 3-bit function code, two operands and a start strobe. The unit accepts a request when `start_ready` is high and `start_valid` is asserted at a rising clock edge. It then runs one iterative datapath for a fixed number of cycles and returns a single result word, marked by a one-cycle `done` pulse.

Signed operands are first converted to magnitudes. One pair of shift registers then serves both jobs. It works as a shift-add multiplier that produces a double-width product, and as a restoring divider that produces quotient and remainder. A final stage restores the sign and selects the word to return. Division by zero and the single signed overflow case give fixed results, so the block needs no exception path. The operand width is a parameter, and the default is 32 bits.

Top module: `muldiv_iter`

## Requirements
- R1: Function code 0 returns the low WIDTH bits of the product of the two operands.
- R2: Function code 1 returns the high WIDTH bits of the double-width product, with both operands taken as two's-complement signed values.
- R3: Function code 2 returns the high WIDTH bits of the product, with `opa` signed and `opb` unsigned.
- R4: Function code 3 returns the high WIDTH bits of the product, with both operands unsigned.
- R5: Function code 4 returns the signed quotient of `opa` divided by `opb`, rounded toward zero. Function code 5 returns the unsigned quotient.
- R6: Function code 6 returns the signed remainder, whose sign follows the dividend `opa`. Function code 7 returns the unsigned remainder.
- R7: When the divisor is zero, codes 4 and 5 return all ones, and codes 6 and 7 return `opa` unchanged.
- R8: For code 4, the most negative value divided by -1 returns the most negative value. For code 6, the same operands return zero.
- R9: `start_ready` is low from the cycle after a request is accepted until the result is delivered. `start_valid` pulses during that time are ignored and never start a second operation.
- R10: `done` rises WIDTH+1 clock cycles after the edge that accepts a request and stays high for exactly one cycle. `result` is valid in that cycle, and `start_ready` is already high in it.
- R11: A synchronous active-high `rst` abandons any operation in progress, drives `done` low and `start_ready` high, and no result from the abandoned request is ever delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Request strobe for a new operation |
| start_ready | output | 1 | High when the unit can accept a request |
| func | input | 3 | Function code selecting the operation (0 to 7) |
| opa | input | WIDTH | First operand (multiplicand or dividend) |
| opb | input | WIDTH | Second operand (multiplier or divisor) |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | WIDTH | Selected result word |

## Verification
Every operation, whatever its code or operands, delivers its result WIDTH+1 cycles after the accepting edge. The bench drives a request, then counts falling edges from the first one after acceptance until `done` is seen. It requires the count to equal WIDTH+1, reads `result` on that same falling edge, and confirms on the next falling edge that `done` has dropped. The ignored-request and reset cases are placed at known cycle offsets inside that window, so each check samples at a falling edge where the expected value is fixed.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   // Function codes; the numeric values are decoded by the unit.
   typedef enum logic [2:0] {
      FN_MUL_LO   = 3'd0,
      FN_MUL_HSS  = 3'd1,
      FN_MUL_HSU  = 3'd2,
      FN_MUL_HUU  = 3'd3,
      FN_QUO_S    = 3'd4,
      FN_QUO_U    = 3'd5,
      FN_REM_S    = 3'd6,
      FN_REM_U    = 3'd7
   } md_fn_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } md_state_e;

   // Division operations have the top code bit set.
   function automatic logic fn_is_div(input logic [2:0] f);
      return f[2];
   endfunction

   // Within division, bit 1 selects the remainder.
   function automatic logic fn_is_rem(input logic [2:0] f);
      return f[2] & f[1];
   endfunction

   function automatic logic fn_a_signed(input logic [2:0] f);
      return (f == FN_MUL_HSS) || (f == FN_MUL_HSU) ||
             (f == FN_QUO_S)   || (f == FN_REM_S);
   endfunction

   function automatic logic fn_b_signed(input logic [2:0] f);
      return (f == FN_MUL_HSS) || (f == FN_QUO_S) || (f == FN_REM_S);
   endfunction

endpackage

// File: rtl/muldiv_operand_prep.sv
module muldiv_operand_prep
   import muldiv_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [2:0]       func,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] mag_a,
   output logic [WIDTH-1:0] mag_b,
   output logic             neg_res
);

   logic a_neg;
   logic b_neg;
   logic b_zero;

   always_comb begin
      a_neg  = fn_a_signed(func) & opa[WIDTH-1];
      b_neg  = fn_b_signed(func) & opb[WIDTH-1];
      b_zero = (opb == '0);
      mag_a  = a_neg ? (~opa + 1'b1) : opa;
      mag_b  = b_neg ? (~opb + 1'b1) : opb;
      if (fn_is_rem(func)) begin
         // remainder follows the dividend sign
         neg_res = a_neg;
      end else if (fn_is_div(func)) begin
         // a zero divisor keeps the all-ones quotient un-negated
         neg_res = (a_neg ^ b_neg) & ~b_zero;
      end else begin
         neg_res = a_neg ^ b_neg;
      end
   end

endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
   parameter int WIDTH = 32
) (
   input  logic             div_mode,
   input  logic [WIDTH-1:0] hi,
   input  logic [WIDTH-1:0] lo,
   input  logic [WIDTH-1:0] opnd,
   output logic [WIDTH-1:0] hi_nxt,
   output logic [WIDTH-1:0] lo_nxt
);

   localparam int EXT_W = WIDTH + 1;

   logic [EXT_W-1:0] sum;
   logic [EXT_W-1:0] shifted;
   logic [WIDTH-1:0] diff;
   logic             borrow;

   always_comb begin
      // shift-add: conditionally add multiplicand, then shift right
      sum = {1'b0, hi} + (lo[0] ? {1'b0, opnd} : {EXT_W{1'b0}});
      // restoring division: shift in next dividend bit, trial subtract
      shifted = {hi, lo[WIDTH-1]};
      borrow  = (shifted < {1'b0, opnd});
      diff    = shifted[WIDTH-1:0] - opnd;
      if (div_mode) begin
         hi_nxt = borrow ? shifted[WIDTH-1:0] : diff;
         lo_nxt = {lo[WIDTH-2:0], ~borrow};
      end else begin
         hi_nxt = sum[EXT_W-1:1];
         lo_nxt = {sum[0], lo[WIDTH-1:1]};
      end
   end

endmodule

// File: rtl/muldiv_result_fix.sv
module muldiv_result_fix
   import muldiv_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [2:0]       func,
   input  logic             neg_res,
   input  logic [WIDTH-1:0] hi,
   input  logic [WIDTH-1:0] lo,
   output logic [WIDTH-1:0] res
);

   localparam int PROD_W = 2 * WIDTH;

   logic [PROD_W-1:0] prod;
   logic [WIDTH-1:0]  div_val;

   always_comb begin
      prod    = neg_res ? (~{hi, lo} + 1'b1) : {hi, lo};
      div_val = fn_is_rem(func) ? hi : lo;
      if (fn_is_div(func)) begin
         res = neg_res ? (~div_val + 1'b1) : div_val;
      end else if (func == FN_MUL_LO) begin
         res = prod[WIDTH-1:0];
      end else begin
         res = prod[PROD_W-1:WIDTH];
      end
   end

endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
   import muldiv_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_valid,
   output logic             start_ready,
   input  logic [2:0]       func,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic             done,
   output logic [WIDTH-1:0] result
);

   localparam int              CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   generate
      if (WIDTH < 2) begin : g_width_chk
         $error("muldiv_iter: WIDTH must be at least 2");
      end
   endgenerate

   md_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [WIDTH-1:0] hi_q, lo_q, opnd_q;
   logic [2:0]       func_q;
   logic             neg_q;
   logic [WIDTH-1:0] result_q;
   logic             done_q;

   logic [WIDTH-1:0] mag_a, mag_b;
   logic             neg_in;
   logic [WIDTH-1:0] hi_nxt, lo_nxt;
   logic [WIDTH-1:0] fix_res;
   logic             accept;

   muldiv_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .func    (func),
      .opa     (opa),
      .opb     (opb),
      .mag_a   (mag_a),
      .mag_b   (mag_b),
      .neg_res (neg_in)
   );

   muldiv_step #(.WIDTH(WIDTH)) u_step (
      .div_mode (fn_is_div(func_q)),
      .hi       (hi_q),
      .lo       (lo_q),
      .opnd     (opnd_q),
      .hi_nxt   (hi_nxt),
      .lo_nxt   (lo_nxt)
   );

   muldiv_result_fix #(.WIDTH(WIDTH)) u_fix (
      .func    (func_q),
      .neg_res (neg_q),
      .hi      (hi_q),
      .lo      (lo_q),
      .res     (fix_res)
   );

   assign start_ready = (state == ST_IDLE);
   assign accept      = start_ready & start_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         hi_q     <= '0;
         lo_q     <= '0;
         opnd_q   <= '0;
         func_q   <= '0;
         neg_q    <= 1'b0;
         result_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  hi_q   <= '0;
                  lo_q   <= fn_is_div(func) ? mag_a : mag_b;
                  opnd_q <= fn_is_div(func) ? mag_b : mag_a;
                  func_q <= func;
                  neg_q  <= neg_in;
                  cnt    <= '0;
                  state  <= ST_RUN;
               end
            end
            ST_RUN: begin
               hi_q <= hi_nxt;
               lo_q <= lo_nxt;
               if (cnt == LAST) begin
                  state <= ST_FIN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_FIN: begin
               result_q <= fix_res;
               done_q   <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done   = done_q;
   assign result = result_q;

endmodule

// File: rtl/muldiv_iter_chk.sv
module muldiv_iter_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             start_valid,
   input logic             start_ready,
   input logic [2:0]       func,
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic             done,
   input logic [WIDTH-1:0] result
);

   localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
   localparam logic [15:0]      LAT      = 16'(WIDTH + 1);

   logic             busy_q;
   logic [15:0]      lat_q;
   logic [2:0]       cap_func;
   logic [WIDTH-1:0] cap_a, cap_b;
   logic             rst_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
         busy_q   <= 1'b0;
         lat_q    <= '0;
         cap_func <= '0;
         cap_a    <= '0;
         cap_b    <= '0;
      end else if (start_valid && start_ready) begin
         busy_q   <= 1'b1;
         lat_q    <= '0;
         cap_func <= func;
         cap_a    <= opa;
         cap_b    <= opb;
      end else if (done) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         lat_q <= lat_q + 1'b1;
      end
   end

   // R9: an accepted request blocks further requests
   a_r9_refuse_busy: assert property (@(posedge clk) disable iff (rst)
      (start_valid && start_ready) |=> !start_ready);

   // R10: done arrives a fixed number of cycles after acceptance
   a_r10_latency: assert property (@(posedge clk) disable iff (rst)
      done |-> (busy_q && lat_q == LAT));

   // R10: done is a single-cycle pulse with ready already restored
   a_r10_one_shot: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r10_ready_at_done: assert property (@(posedge clk) disable iff (rst)
      done |-> start_ready);

   // R7: zero divisor on quotient codes gives all ones
   a_r7_div_zero: assert property (@(posedge clk) disable iff (rst)
      (done && cap_func[2] && !cap_func[1] && cap_b == '0) |-> (result == '1));

   // R8: signed overflow quotient
   a_r8_overflow: assert property (@(posedge clk) disable iff (rst)
      (done && cap_func == 3'd4 && cap_a == MOST_NEG && cap_b == '1)
      |-> (result == MOST_NEG));

   // R11: the cycle after a reset edge shows an idle unit
   always @(negedge clk) begin
      if (rst_q === 1'b1) begin
         a_r11_reset_idle: assert (!done && start_ready);
      end
   end

endmodule

bind muldiv_iter muldiv_iter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .start_valid (start_valid),
   .start_ready (start_ready),
   .func        (func),
   .opa         (opa),
   .opb         (opb),
   .done        (done),
   .result      (result)
);

// File: tb/muldiv_iter_tb.sv
`timescale 1ns/1ps
module muldiv_iter_tb;

   localparam int W   = 4;
   localparam int N   = 1 << W;
   localparam int LAT = W + 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start_valid = 1'b0;
   logic [2:0]   func = '0;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic         start_ready;
   logic         done;
   logic [W-1:0] result;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   muldiv_iter #(.WIDTH(W)) u_dut (
      .clk         (clk),
      .rst         (rst),
      .start_valid (start_valid),
      .start_ready (start_ready),
      .func        (func),
      .opa         (opa),
      .opb         (opb),
      .done        (done),
      .result      (result)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int sx(input int v);
      return (v >= N / 2) ? v - N : v;
   endfunction

   function automatic int model(input int f, input int a, input int b);
      int sa, sb, r;
      sa = sx(a);
      sb = sx(b);
      r  = 0;
      case (f)
         0: r = a * b;
         1: r = (sa * sb) >>> W;
         2: r = (sa * b) >>> W;
         3: r = (a * b) >> W;
         4: if (b == 0) r = -1;
            else if (sa == -N / 2 && sb == -1) r = sa;
            else r = sa / sb;
         5: r = (b == 0) ? -1 : a / b;
         6: if (b == 0) r = a;
            else if (sa == -N / 2 && sb == -1) r = 0;
            else r = sa % sb;
         7: r = (b == 0) ? a : a % b;
         default: r = 0;
      endcase
      return r & (N - 1);
   endfunction

   function automatic string tag_of(input int f, input int a, input int b);
      if (f == 0) return "R1";
      if (f == 1) return "R2";
      if (f == 2) return "R3";
      if (f == 3) return "R4";
      if (b == 0) return "R7";
      if ((f == 4 || f == 6) && sx(a) == -N / 2 && sx(b) == -1) return "R8";
      if (f < 6) return "R5";
      return "R6";
   endfunction

   task automatic run_op(input int f, input int a, input int b,
                         output logic [W-1:0] res, output int lat);
      @(negedge clk);
      func        = f[2:0];
      opa         = a[W-1:0];
      opb         = b[W-1:0];
      start_valid = 1'b1;
      @(negedge clk);
      start_valid = 1'b0;
      lat = 0;
      while (done !== 1'b1 && lat < 4 * LAT) begin
         @(negedge clk);
         lat++;
      end
      res = result;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] res;
      int lat;
      int extra;

      // R11: reset state
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R11 done after reset", {31'd0, done}, 32'd0);
      check("R11 ready after reset", {31'd0, start_ready}, 32'd1);

      // R9: busy unit refuses and ignores a second request
      @(negedge clk);
      func = 3'd3; opa = 4'hF; opb = 4'hF; start_valid = 1'b1;
      @(negedge clk);
      check("R9 ready low while busy", {31'd0, start_ready}, 32'd0);
      func = 3'd0; opa = 4'd3; opb = 4'd3;
      lat = 0;
      while (done !== 1'b1 && lat < 4 * LAT) begin
         @(negedge clk);
         lat++;
         if (lat == LAT - 1) start_valid = 1'b0;
      end
      check("R9 first result kept", {28'd0, result}, 32'd14);
      check("R10 latency", lat, LAT);
      extra = 0;
      repeat (2 * LAT) begin
         @(negedge clk);
         if (done === 1'b1) extra++;
      end
      check("R9 no second done", extra, 0);

      // R11: reset in the middle of an operation
      @(negedge clk);
      func = 3'd5; opa = 4'hF; opb = 4'd1; start_valid = 1'b1;
      @(negedge clk);
      start_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R11 ready after mid reset", {31'd0, start_ready}, 32'd1);
      check("R11 done after mid reset", {31'd0, done}, 32'd0);
      extra = 0;
      repeat (2 * LAT) begin
         @(negedge clk);
         if (done === 1'b1) extra++;
      end
      check("R11 abandoned op silent", extra, 0);

      // exhaustive sweep: R1..R8 results, R10 timing on every operation
      for (int f = 0; f < 8; f++) begin
         for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
               run_op(f, a, b, res, lat);
               check(tag_of(f, a, b), {28'd0, res}, model(f, a, b));
               check("R10 latency", lat, LAT);
               @(negedge clk);
               check("R10 single-cycle done", {31'd0, done}, 32'd0);
            end
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule